// File: doc/BRIEF.md
# Accumulator Machine Instruction Cycle Sequencer

This block is the control core and register set of a small accumulator machine. A sequence counter steps through one-hot timing states, and every register transfer is gated by the current state and the decoded opcode. Each instruction follows the same path. The word at the program counter is fetched into the instruction register and the program counter advances. The opcode field is decoded, and the indirect bit is captured. For a memory-reference instruction, the address may then be resolved through one level of indirection. The execute states follow, and the last of them returns the counter to the first state.

An interrupt request flip-flop replaces the fetch with a three-state hardware call. The return address is saved in word 0, and execution restarts at word 1 with interrupts disabled. Memory sits outside the block. The block drives an address taken from its address register, a write strobe, and write data taken from its internal bus. Read data comes back combinationally for the currently addressed word. Registers move values over a shared bus, and a 3-bit source code selects which register drives it.

Top module: `acm_sequencer`

## Requirements
- R1: The timing output `t_state` is one-hot and is bit 0 (T0) after reset. It advances one state per rising edge. It returns to T0 on the edge after any state that ends an instruction, and it wraps from the last state to T0.
- R2: After reset, `prog_cnt` and `accum` are 0, `irq_cycle` is 0 and interrupts are disabled.
- R3: Without a pending interrupt, fetch works as follows. In T0, `bus_sel` is 3'b010 (program counter) and the address register takes the program counter. In T1, `bus_sel` is 3'b111 (memory), the instruction register takes the addressed word and the program counter increments.
- R4: In T2, instruction bit 15 is latched as the indirect flag, bits 14..12 are decoded into one of eight opcode lines, and bits 11..0 are loaded into the address register (visible on `mem_addr`).
- R5: In T3, an instruction with an opcode other than 7 and the indirect flag set loads the address register from the addressed word. With the flag clear, the address is left unchanged. Opcode 7 is never dereferenced and ends at T3.
- R6: Opcode 2 (load) moves the addressed word to the data register in T4 and to the accumulator in T5, then ends.
- R7: Opcode 3 (store) writes the accumulator to the addressed word in T4, then ends.
- R8: Opcode 4 (jump) loads the program counter from the address register in T4, then ends.
- R9: Opcode 5 (call) writes the zero-extended program counter to the addressed word and increments the address register in T4. It loads the program counter from the address register in T5. The 12-bit increment wraps.
- R10: Opcodes 0, 1 and 6 end at T4 and change no register or memory word.
- R11: The interrupt flip-flop is set on an edge where the state is not T0, T1 or T2, interrupts are enabled, and `flag_in` or `flag_out` is 1. It is never set while interrupts are disabled.
- R12: The interrupt cycle runs over three states. In state 0, the address register is cleared and the temporary register takes the program counter. In state 1, word 0 takes the saved program counter and the program counter is cleared. In state 2, the program counter increments to 1, interrupts are disabled, the interrupt flip-flop clears, and the timing returns to T0.
- R13: A high `ien_set` at an edge enables interrupts from that edge on. Disabling in interrupt state 2 takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ien_set | input | 1 | Enable interrupts at the next edge |
| flag_in | input | 1 | Input-ready flag |
| flag_out | input | 1 | Output-ready flag |
| mem_rdata | input | 16 | Word at `mem_addr` |
| mem_addr | output | 12 | Memory address (address register) |
| mem_wdata | output | 16 | Write data (bus value) |
| mem_we | output | 1 | Memory write strobe |
| bus_sel | output | 3 | Bus source code |
| t_state | output | 16 | One-hot timing state |
| prog_cnt | output | 12 | Program counter |
| accum | output | 16 | Accumulator |
| irq_cycle | output | 1 | Interrupt flip-flop |

## Verification
The bench builds the block with its defaults: a 12-bit address, a 16-bit word and a 4-bit sequence counter. The full 4096-word space therefore sits behind the address register, so a call to the top word wraps the return target to address 0. The bench sweeps all eight opcode lines, with both settings of the indirect bit, over eight address fields spread across that space. It also places interrupt requests from each flag both before and after interrupts are enabled. This exposes the gating of the request in T0 to T2 and the one-edge latency of the enable.

// File: rtl/acm_pkg.sv
package acm_pkg;
  localparam int OP_W = 3;

  typedef enum logic [2:0] {
    BUS_NONE = 3'b000,
    BUS_AR   = 3'b001,
    BUS_PC   = 3'b010,
    BUS_DR   = 3'b011,
    BUS_AC   = 3'b100,
    BUS_IR   = 3'b101,
    BUS_TR   = 3'b110,
    BUS_MEM  = 3'b111
  } bus_src_e;

  localparam int OPC_LOAD  = 2;
  localparam int OPC_STORE = 3;
  localparam int OPC_JUMP  = 4;
  localparam int OPC_CALL  = 5;
  localparam int OPC_NONMR = 7;
endpackage

// File: rtl/acm_seq_timer.sv
module acm_seq_timer #(
  parameter int SC_W = 4,
  localparam int T_N = 2 ** SC_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  output logic [T_N-1:0] t_onehot
);
  logic [SC_W-1:0] sc_q;
  logic [SC_W-1:0] sc_d;

  always_comb begin
    if (clr) sc_d = '0;
    else     sc_d = sc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sc_q <= '0;
    else        sc_q <= sc_d;
  end

  for (genvar g = 0; g < T_N; g++) begin : g_tdec
    assign t_onehot[g] = (sc_q == SC_W'(g));
  end
endmodule

// File: rtl/acm_op_decode.sv
module acm_op_decode #(
  parameter int OP_W = 3,
  localparam int D_N = 2 ** OP_W
) (
  input  logic [OP_W-1:0] op,
  output logic [D_N-1:0]  dec
);
  for (genvar g = 0; g < D_N; g++) begin : g_odec
    assign dec[g] = (op == OP_W'(g));
  end
endmodule

// File: rtl/acm_bus_mux.sv
module acm_bus_mux
  import acm_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16
) (
  input  bus_src_e            sel,
  input  logic [ADDR_W-1:0]   ar,
  input  logic [ADDR_W-1:0]   pc,
  input  logic [WORD_W-1:0]   dr,
  input  logic [WORD_W-1:0]   ac,
  input  logic [WORD_W-1:0]   ir,
  input  logic [WORD_W-1:0]   tr,
  input  logic [WORD_W-1:0]   mem,
  output logic [WORD_W-1:0]   bus
);
  localparam int PAD_W = WORD_W - ADDR_W;

  always_comb begin
    unique case (sel)
      BUS_AR:  bus = {{PAD_W{1'b0}}, ar};
      BUS_PC:  bus = {{PAD_W{1'b0}}, pc};
      BUS_DR:  bus = dr;
      BUS_AC:  bus = ac;
      BUS_IR:  bus = ir;
      BUS_TR:  bus = tr;
      BUS_MEM: bus = mem;
      default: bus = '0;
    endcase
  end
endmodule

// File: rtl/acm_sequencer.sv
module acm_sequencer
  import acm_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16,
  parameter int SC_W   = 4,
  localparam int T_N   = 2 ** SC_W,
  localparam int D_N   = 2 ** OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ien_set,
  input  logic              flag_in,
  input  logic              flag_out,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [2:0]        bus_sel,
  output logic [T_N-1:0]    t_state,
  output logic [ADDR_W-1:0] prog_cnt,
  output logic [WORD_W-1:0] accum,
  output logic              irq_cycle
);
  logic [ADDR_W-1:0] ar_q, ar_d, pc_q, pc_d;
  logic [WORD_W-1:0] ir_q, ir_d, dr_q, dr_d, ac_q, ac_d, tr_q, tr_d;
  logic              i_q, i_d, r_q, r_d, ien_q, ien_d;
  logic [WORD_W-1:0] bus;
  logic [D_N-1:0]    dop;
  logic [T_N-1:0]    t;
  bus_src_e          sel;
  logic              sc_clr;

  acm_seq_timer #(.SC_W(SC_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(sc_clr), .t_onehot(t)
  );

  acm_op_decode #(.OP_W(OP_W)) u_opdec (
    .op(ir_q[WORD_W-2 -: OP_W]), .dec(dop)
  );

  acm_bus_mux #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_bus (
    .sel(sel), .ar(ar_q), .pc(pc_q), .dr(dr_q), .ac(ac_q),
    .ir(ir_q), .tr(tr_q), .mem(mem_rdata), .bus(bus)
  );

  // decoded control terms
  logic fetch0, fetch1, dec2, int0, int1, int2, ind3, nonmr3;
  logic ld4, ld5, st4, jmp4, call4, call5, idle4, memref;

  always_comb begin
    memref = ~dop[OPC_NONMR];
    fetch0 = ~r_q & t[0];
    fetch1 = ~r_q & t[1];
    dec2   = ~r_q & t[2];
    int0   =  r_q & t[0];
    int1   =  r_q & t[1];
    int2   =  r_q & t[2];
    ind3   = memref & i_q & t[3];
    nonmr3 = dop[OPC_NONMR] & t[3];
    ld4    = dop[OPC_LOAD]  & t[4];
    ld5    = dop[OPC_LOAD]  & t[5];
    st4    = dop[OPC_STORE] & t[4];
    jmp4   = dop[OPC_JUMP]  & t[4];
    call4  = dop[OPC_CALL]  & t[4];
    call5  = dop[OPC_CALL]  & t[5];
    idle4  = memref & t[4] & ~(dop[OPC_LOAD] | dop[OPC_STORE] |
                               dop[OPC_JUMP] | dop[OPC_CALL]);
  end

  // bus source selection
  always_comb begin
    if (fetch0 | int0 | call4)        sel = BUS_PC;
    else if (fetch1 | ind3 | ld4)     sel = BUS_MEM;
    else if (dec2)                    sel = BUS_IR;
    else if (ld5)                     sel = BUS_DR;
    else if (st4)                     sel = BUS_AC;
    else if (jmp4 | call5)            sel = BUS_AR;
    else if (int1)                    sel = BUS_TR;
    else                              sel = BUS_NONE;
  end

  // next-state logic
  always_comb begin
    ar_d  = ar_q;
    pc_d  = pc_q;
    ir_d  = ir_q;
    dr_d  = dr_q;
    ac_d  = ac_q;
    tr_d  = tr_q;
    i_d   = i_q;
    r_d   = r_q;
    ien_d = ien_q;

    if (fetch0 | dec2 | ind3) ar_d = bus[ADDR_W-1:0];
    else if (int0)            ar_d = '0;
    else if (call4)           ar_d = ar_q + 1'b1;

    if (fetch1 | int2)        pc_d = pc_q + 1'b1;
    else if (jmp4 | call5)    pc_d = bus[ADDR_W-1:0];
    else if (int1)            pc_d = '0;

    if (fetch1) ir_d = bus;
    if (ld4)    dr_d = bus;
    if (ld5)    ac_d = bus;
    if (int0)   tr_d = bus;
    if (dec2)   i_d  = ir_q[WORD_W-1];

    if (int2) r_d = 1'b0;
    else if (~(t[0] | t[1] | t[2]) & ien_q & (flag_in | flag_out)) r_d = 1'b1;

    if (int2)         ien_d = 1'b0;
    else if (ien_set) ien_d = 1'b1;

    sc_clr = nonmr3 | ld5 | st4 | jmp4 | call5 | idle4 | int2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ar_q  <= '0;
      pc_q  <= '0;
      ir_q  <= '0;
      dr_q  <= '0;
      ac_q  <= '0;
      tr_q  <= '0;
      i_q   <= 1'b0;
      r_q   <= 1'b0;
      ien_q <= 1'b0;
    end else begin
      ar_q  <= ar_d;
      pc_q  <= pc_d;
      ir_q  <= ir_d;
      dr_q  <= dr_d;
      ac_q  <= ac_d;
      tr_q  <= tr_d;
      i_q   <= i_d;
      r_q   <= r_d;
      ien_q <= ien_d;
    end
  end

  assign mem_addr  = ar_q;
  assign mem_wdata = bus;
  assign mem_we    = st4 | call4 | int1;
  assign bus_sel   = sel;
  assign t_state   = t;
  assign prog_cnt  = pc_q;
  assign accum     = ac_q;
  assign irq_cycle = r_q;
endmodule

// File: rtl/acm_sequencer_chk.sv
module acm_sequencer_chk #(
  parameter int ADDR_W = 12,
  parameter int SC_W   = 4,
  localparam int T_N   = 2 ** SC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [T_N-1:0]    t_state,
  input logic              sc_clr,
  input logic [2:0]        bus_sel,
  input logic              irq_cycle,
  input logic              ien_q,
  input logic [ADDR_W-1:0] pc,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(t_state) == 1);

  a_r1_advance: assert property (@(posedge clk) disable iff (!rst_n)
    !sc_clr |=> t_state == (($past(t_state) << 1) | ($past(t_state) >> (T_N-1))));

  a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sc_clr |=> t_state[0]);

  a_r3_fetch_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (t_state[0] && !irq_cycle) |-> bus_sel == 3'b010);

  a_r3_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (t_state[1] && !irq_cycle) |=> pc == $past(pc) + 1'b1);

  a_r11_no_req_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_q && !irq_cycle) |=> !irq_cycle);

  a_r12_save_word0: assert property (@(posedge clk) disable iff (!rst_n)
    (t_state[1] && irq_cycle) |-> (mem_we && mem_addr == '0));

  a_r12_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (t_state[2] && irq_cycle) |=> (!irq_cycle && !ien_q && pc == 1));

  a_r7_write_src: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (bus_sel == 3'b100 || bus_sel == 3'b010 || bus_sel == 3'b110));
endmodule

bind acm_sequencer acm_sequencer_chk #(.ADDR_W(ADDR_W), .SC_W(SC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .t_state(t_state), .sc_clr(sc_clr),
  .bus_sel(bus_sel), .irq_cycle(irq_cycle), .ien_q(ien_q), .pc(pc_q),
  .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/acm_sequencer_tb.sv
`timescale 1ns/1ps
module acm_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ien_set = 1'b0, flag_in = 1'b0, flag_out = 1'b0;
  logic [15:0] mem_rdata, mem_wdata;
  logic [11:0] mem_addr, prog_cnt;
  logic        mem_we, irq_cycle;
  logic [2:0]  bus_sel;
  logic [15:0] t_state, accum;

  logic        tb_we = 1'b0;
  logic [11:0] tb_addr = '0;
  logic [15:0] tb_data = '0;
  logic [15:0] mem [0:4095];

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  acm_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .ien_set(ien_set), .flag_in(flag_in),
    .flag_out(flag_out), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .bus_sel(bus_sel),
    .t_state(t_state), .prog_cnt(prog_cnt), .accum(accum),
    .irq_cycle(irq_cycle)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (tb_we)       mem[tb_addr] <= tb_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // write one word while the design is held in reset
  task automatic poke(input logic [11:0] a, input logic [15:0] d);
    rst_n = 1'b0; tb_we = 1'b1; tb_addr = a; tb_data = d;
    @(posedge clk); @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic release_rst();
    @(negedge clk); rst_n = 1'b1;
  endtask

  function automatic logic [15:0] instr(input bit ind, input int op, input logic [11:0] f);
    return {ind, 3'(op), f};
  endfunction

  // preload: word0 loads the pattern from word 15
  task automatic setup_base(input logic [15:0] pat);
    poke(12'h000, instr(0, 2, 12'h00F));
    poke(12'h00F, pat);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R2 / R1 / R3 reset state and first fetch
    setup_base(16'h1234);
    poke(12'h001, instr(0, 7, 12'h000));
    release_rst();
    chk("R1 reset state T0", t_state, 16'h0001);
    chk("R2 reset pc", prog_cnt, 0);
    chk("R2 reset ac", accum, 0);
    chk("R2 reset irq", irq_cycle, 0);
    chk("R3 T0 bus select", bus_sel, 3'b010);
    chk("R7 no write at T0", mem_we, 0);
    step(1);
    chk("R1 advance to T1", t_state, 16'h0002);
    chk("R3 T1 bus select", bus_sel, 3'b111);
    chk("R3 T1 address from pc", mem_addr, 12'h000);
    step(1);
    chk("R3 pc incremented", prog_cnt, 1);

    // sweep: opcode x indirect x address field
    for (int k = 0; k < 8; k++) begin
      for (int ind = 0; ind < 2; ind++) begin
        for (int op = 0; op < 8; op++) begin
          logic [11:0] fld, tgt, ea;
          logic [15:0] pat, dat;
          fld = 12'h010 + 12'(k) * 12'h1F3;
          tgt = fld ^ 12'h800;
          ea  = (ind == 1 && op != 7) ? tgt : fld;
          pat = 16'hC35A ^ (16'(k) * 16'h0111) ^ 16'(op);
          dat = ~pat;
          setup_base(pat);
          poke(12'h001, instr(ind[0], op, fld));
          if (ind == 1) begin
            poke(fld, {4'h0, tgt});
            poke(tgt, dat);
          end else begin
            poke(fld, dat);
          end
          release_rst();
          step(6);
          chk("R6 load pattern", accum, pat);
          chk("R6 load ends at T0", t_state, 16'h0001);
          step(3);
          chk("R4 field in address reg", mem_addr, fld);
          chk("R1 in T3", t_state, 16'h0008);
          step(1);
          if (op == 7) begin
            chk("R5 opcode 7 ends at T3", t_state, 16'h0001);
            chk("R5 opcode 7 not dereferenced", mem_addr, fld);
            chk("R5 opcode 7 pc", prog_cnt, 2);
          end else begin
            chk("R5 effective address", mem_addr, ea);
            case (op)
              2: begin
                step(2);
                chk("R6 load result", accum, dat);
                chk("R6 load done", t_state, 16'h0001);
              end
              3: begin
                step(1);
                chk("R7 store word", mem[ea], pat);
                chk("R7 store done", t_state, 16'h0001);
                chk("R7 store pc", prog_cnt, 2);
              end
              4: begin
                step(1);
                chk("R8 jump pc", prog_cnt, ea);
                chk("R8 jump done", t_state, 16'h0001);
              end
              5: begin
                step(2);
                chk("R9 call saved pc", mem[ea], 16'h0002);
                chk("R9 call pc", prog_cnt, ea + 12'h001);
                chk("R9 call done", t_state, 16'h0001);
              end
              default: begin
                step(1);
                chk("R10 idle op done", t_state, 16'h0001);
                chk("R10 idle op pc", prog_cnt, 2);
                chk("R10 idle op ac", accum, pat);
                chk("R10 idle op memory", mem[ea], dat);
              end
            endcase
          end
        end
      end
    end

    // R9 call at the top word wraps
    setup_base(16'h0F0F);
    poke(12'h001, instr(0, 5, 12'hFFF));
    release_rst();
    step(12);
    chk("R9 top word saved pc", mem[4095], 16'h0002);
    chk("R9 wrapped pc", prog_cnt, 0);

    // R11 / R12 / R13 interrupt from each flag
    for (int src = 0; src < 2; src++) begin
      setup_base(16'hBEEF);
      poke(12'h001, instr(0, 4, 12'h040));
      release_rst();
      flag_in = (src == 0); flag_out = (src == 1);
      ien_set = 1'b1;
      step(1);
      ien_set = 1'b0;
      step(2);
      chk("R11 not set in T0..T2", irq_cycle, 0);
      step(1);
      chk("R11 set after T3", irq_cycle, 1);
      step(2);
      chk("R11 instruction completes", accum, 16'hBEEF);
      chk("R12 back to T0", t_state, 16'h0001);
      step(1);
      chk("R12 state0 address cleared", mem_addr, 0);
      step(1);
      chk("R12 return saved in word0", mem[0], 16'h0001);
      chk("R12 pc cleared", prog_cnt, 0);
      step(1);
      chk("R12 resume pc", prog_cnt, 1);
      chk("R12 flip-flop cleared", irq_cycle, 0);
      chk("R12 resume T0", t_state, 16'h0001);
      step(5);
      chk("R13 disabled after interrupt pc", prog_cnt, 12'h040);
      chk("R13 disabled after interrupt irq", irq_cycle, 0);
      flag_in = 1'b0; flag_out = 1'b0;
    end

    // R11 flags without enable
    setup_base(16'h7777);
    poke(12'h001, instr(0, 7, 12'h000));
    release_rst();
    flag_in = 1'b1; flag_out = 1'b1;
    step(6);
    chk("R11 no request while disabled", irq_cycle, 0);
    step(1);
    chk("R11 normal fetch continues", t_state, 16'h0002);
    chk("R11 word0 untouched", mem[0], instr(0, 2, 12'h00F));
    flag_in = 1'b0; flag_out = 1'b0;

    // R13 enable one edge late: pulse before the T4 edge
    setup_base(16'h2222);
    release_rst();
    flag_out = 1'b1;
    step(4);
    ien_set = 1'b1;
    step(1);
    ien_set = 1'b0;
    chk("R13 enable not yet effective", irq_cycle, 0);
    step(1);
    chk("R13 request after enable", irq_cycle, 1);
    flag_out = 1'b0;

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule